// File: doc/BRIEF.md
# Audio Sample Compact Float Codec

This block converts audio samples between a 24-bit two's-complement form and a 16-bit compact floating-point word used to save space in delay-line memory. The encoder counts how many top bits of the sample merely repeat the sign. It records that count as an exponent, capped at 12. It then keeps the eleven bits that follow the first bit that differs from the sign. The decoder rebuilds the leading bits from the sign and shifts the mantissa back into place. The leading bit is the inverted sign, not a constant one, so the format is not IEEE-like. Large samples lose low bits to truncation. Small ones survive a round trip unchanged.

Each direction is an independent stream with a valid/ready handshake. A word moves across an edge only in a cycle where valid and ready are both high. The parameter `OUT_REG` picks the build. With `OUT_REG` = 1, the default, each direction has one output register. Its input ready is high when that register is empty or the downstream side is ready. A stalled output keeps its data and valid until it is taken. With `OUT_REG` = 0 the conversion is combinational: valid passes forward and ready passes backward unchanged.

Top module: `sfp_codec`

## Requirements
- R1: The packed word carries the sign in bit 15, the exponent in bits 14:11 and the mantissa in bits 10:0. The sign is bit 23 of the sample.
- R2: The pack exponent is the number of consecutive positions, counted down from the top, where bit 23-i equals bit 22-i, for i = 0 upwards, saturating at 12.
- R3: For a pack exponent below 12, the mantissa is bits 21:11 of the sample shifted left by the exponent.
- R4: For a pack exponent of 12, the mantissa is sample bits 10:0 and the exponent field reads 12.
- R5: On unpack with an exponent field of 0 to 11, the rebuilt value is built as follows. Bit 23 is the sign, bit 22 is the inverted sign, bits 21:11 are the mantissa and the low bits are zero. That value is shifted right arithmetically by the exponent.
- R6: On unpack with an exponent field of 12 to 15, the shift is 11. Bit 22 copies the sign, so no leading bit is inserted.
- R7: Unpacking a packed sample returns it exactly for samples from -4096 to 4095. For any other sample y, the result is at most y and falls short of y by less than 2^(11-exponent).
- R8: In the registered build, each result appears one cycle after its input transfer. A stalled output holds its data and valid. Input ready is low only while the output is full and not ready.
- R9: An active-low reset clears both output valids at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pk_in_valid | input | 1 | Sample offered to the encoder |
| pk_in_ready | output | 1 | Encoder accepts a sample |
| pk_in_data | input | 24 | Two's-complement sample |
| pk_out_valid | output | 1 | Packed word available |
| pk_out_ready | input | 1 | Consumer takes the packed word |
| pk_out_data | output | 16 | Packed word |
| up_in_valid | input | 1 | Packed word offered to the decoder |
| up_in_ready | output | 1 | Decoder accepts a word |
| up_in_data | input | 16 | Packed word |
| up_out_valid | output | 1 | Rebuilt sample available |
| up_out_ready | input | 1 | Consumer takes the sample |
| up_out_data | output | 24 | Rebuilt two's-complement sample |

## Verification
In the default build, both the packed word and the rebuilt sample are due at the first rising edge after their input transfer. The bench drives inputs on falling edges and reads each result at the falling edge that follows that rising edge. In the stall test, the output is held over extra cycles with ready low. The bench re-reads it at each falling edge, confirms the value has not moved, and reads the next result only one edge after ready returns.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int SMP_W   = 24;
  localparam int WRD_W   = 16;
  localparam int MAN_W   = 11;
  localparam int EXP_W   = 4;
  localparam int EXP_SAT = 12;
  localparam int SHF_MAX = EXP_SAT - 1;
  localparam int LOW_W   = SMP_W - 2 - MAN_W;
endpackage

// File: rtl/sfp_pack_core.sv
module sfp_pack_core
  import sfp_pkg::*;
(
  input  logic [SMP_W-1:0] smp,
  output logic [WRD_W-1:0] word
);
  logic [SMP_W-1:0] diff;
  logic [SMP_W-1:0] norm;
  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] man;

  always_comb begin
    diff = smp ^ {smp[SMP_W-2:0], 1'b0};
    expo = EXP_W'(EXP_SAT);
    for (int k = EXP_SAT - 1; k >= 0; k--) begin
      if (diff[SMP_W-1-k]) expo = EXP_W'(k);
    end
  end

  assign norm = smp << expo;
  assign man  = (expo == EXP_W'(EXP_SAT)) ? smp[MAN_W-1:0] : norm[SMP_W-3 -: MAN_W];
  assign word = {smp[SMP_W-1], expo, man};

  // R3
  always_comb begin
    if (expo < EXP_W'(EXP_SAT)) begin
      norm_lead_chk: assert (norm[SMP_W-1] != norm[SMP_W-2]);
    end
  end
endmodule

// File: rtl/sfp_unpack_core.sv
module sfp_unpack_core
  import sfp_pkg::*;
(
  input  logic [WRD_W-1:0] word,
  output logic [SMP_W-1:0] smp
);
  logic             sgn;
  logic [EXP_W-1:0] expo;
  logic [EXP_W-1:0] shamt;
  logic             sat;
  logic [SMP_W-1:0] pre;

  assign sgn   = word[WRD_W-1];
  assign expo  = word[WRD_W-2 -: EXP_W];
  assign sat   = expo > EXP_W'(SHF_MAX);
  assign shamt = sat ? EXP_W'(SHF_MAX) : expo;
  assign pre   = {sgn, (sat ? sgn : ~sgn), word[MAN_W-1:0], {LOW_W{1'b0}}};
  assign smp   = $signed(pre) >>> shamt;

  // R5
  always_comb begin
    sign_keep_chk: assert (smp[SMP_W-1] == sgn);
  end
endmodule

// File: rtl/sfp_stream_stage.sv
module sfp_stream_stage #(
  parameter int W   = 16,
  parameter bit REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  generate
    if (REG) begin : g_reg
      logic         v_q;
      logic [W-1:0] d_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q <= 1'b0;
          d_q <= '0;
        end else if (in_ready) begin
          v_q <= in_valid;
          if (in_valid) d_q <= in_data;
        end
      end

      assign in_ready  = !v_q || out_ready;
      assign out_valid = v_q;
      assign out_data  = d_q;

      // R8
      hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    end else begin : g_pass
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign in_ready   = out_ready;
      assign out_valid  = in_valid;
      assign out_data   = in_data;
    end
  endgenerate
endmodule

// File: rtl/sfp_codec.sv
module sfp_codec
  import sfp_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pk_in_valid,
  output logic             pk_in_ready,
  input  logic [SMP_W-1:0] pk_in_data,
  output logic             pk_out_valid,
  input  logic             pk_out_ready,
  output logic [WRD_W-1:0] pk_out_data,
  input  logic             up_in_valid,
  output logic             up_in_ready,
  input  logic [WRD_W-1:0] up_in_data,
  output logic             up_out_valid,
  input  logic             up_out_ready,
  output logic [SMP_W-1:0] up_out_data
);
  logic [WRD_W-1:0] pk_word;
  logic [SMP_W-1:0] up_smp;

  sfp_pack_core i_pack (.smp(pk_in_data), .word(pk_word));
  sfp_unpack_core i_unpack (.word(up_in_data), .smp(up_smp));

  sfp_stream_stage #(.W(WRD_W), .REG(OUT_REG)) i_pk_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(pk_in_valid), .in_ready(pk_in_ready), .in_data(pk_word),
    .out_valid(pk_out_valid), .out_ready(pk_out_ready), .out_data(pk_out_data)
  );

  sfp_stream_stage #(.W(SMP_W), .REG(OUT_REG)) i_up_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(up_in_valid), .in_ready(up_in_ready), .in_data(up_smp),
    .out_valid(up_out_valid), .out_ready(up_out_ready), .out_data(up_out_data)
  );

  // R2
  exp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pk_out_valid |-> (pk_out_data[WRD_W-2 -: EXP_W] <= EXP_W'(EXP_SAT)));
endmodule

// File: tb/test_sfp_codec.sv
`timescale 1ns/1ps
module test_sfp_codec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pk_in_valid = 1'b0;
  logic        pk_in_ready;
  logic [23:0] pk_in_data = '0;
  logic        pk_out_valid;
  logic        pk_out_ready = 1'b1;
  logic [15:0] pk_out_data;
  logic        up_in_valid = 1'b0;
  logic        up_in_ready;
  logic [15:0] up_in_data = '0;
  logic        up_out_valid;
  logic        up_out_ready = 1'b1;
  logic [23:0] up_out_data;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #2.5 clk = ~clk;

  sfp_codec i_sfp_codec (
    .clk(clk), .rst_n(rst_n),
    .pk_in_valid(pk_in_valid), .pk_in_ready(pk_in_ready), .pk_in_data(pk_in_data),
    .pk_out_valid(pk_out_valid), .pk_out_ready(pk_out_ready), .pk_out_data(pk_out_data),
    .up_in_valid(up_in_valid), .up_in_ready(up_in_ready), .up_in_data(up_in_data),
    .up_out_valid(up_out_valid), .up_out_ready(up_out_ready), .up_out_data(up_out_data)
  );

  // sample, packed word, unpack of that word
  localparam logic [63:0] VEC [13] = '{
    {24'h000000, 16'h6000, 24'h000000},
    {24'hFFFFFF, 16'hE7FF, 24'hFFFFFF},
    {24'h000005, 16'h6005, 24'h000005},
    {24'h7FFFFF, 16'h07FF, 24'h7FF800},
    {24'h800000, 16'h8000, 24'h800000},
    {24'h000800, 16'h5800, 24'h000800},
    {24'hFFF800, 16'hE000, 24'hFFF800},
    {24'hFFF7FF, 16'hDFFF, 24'hFFF7FF},
    {24'h123456, 16'h111A, 24'h123400},
    {24'h0007FF, 16'h67FF, 24'h0007FF},
    {24'hC00000, 16'h8800, 24'hC00000},
    {24'h400000, 16'h0000, 24'h400000},
    {24'h000FFF, 16'h5FFF, 24'h000FFF}
  };

  task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic xfer(input logic [23:0] x, input logic [15:0] w,
                      output logic [15:0] wo, output logic [23:0] yo);
    @(negedge clk);
    pk_in_valid = 1'b1; pk_in_data = x;
    up_in_valid = 1'b1; up_in_data = w;
    @(negedge clk);
    chk(pk_out_valid && up_out_valid, "R8 result valid one cycle later",
        {22'd0, pk_out_valid, up_out_valid}, 24'd3);
    wo = pk_out_data;
    yo = up_out_data;
    pk_in_valid = 1'b0;
    up_in_valid = 1'b0;
  endtask

  function automatic int lead(input logic [23:0] x);
    int n = 0;
    for (int i = 0; i < 12; i++)
      if (n == i && x[23-i] == x[22-i]) n++;
    return n;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] wo;
    logic [23:0] yo;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!pk_out_valid && !up_out_valid, "R9 valids low in reset",
        {22'd0, pk_out_valid, up_out_valid}, 24'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pk_in_ready && up_in_ready, "R8 ready after reset",
        {22'd0, pk_in_ready, up_in_ready}, 24'd3);

    // table: R1 R2 R3 R4 on pack, R5 R6 on unpack
    for (int i = 0; i < 13; i++) begin
      xfer(VEC[i][63:40], VEC[i][39:24], wo, yo);
      chk(wo == VEC[i][39:24], "R1 R2 R3 R4 pack word", {8'd0, wo}, {8'd0, VEC[i][39:24]});
      chk(yo == VEC[i][23:0], "R5 R6 unpack sample", yo, VEC[i][23:0]);
    end

    // R6 saturated exponents 13..15 act as 11 with no leading bit
    xfer(24'h0, 16'h7805, wo, yo);
    chk(yo == 24'h000005, "R6 exp 15 positive", yo, 24'h000005);
    xfer(24'h0, 16'hF805, wo, yo);
    chk(yo == 24'hFFF805, "R6 exp 15 negative", yo, 24'hFFF805);
    xfer(24'h0, 16'h6AAA, wo, yo);
    chk(yo == 24'h0002AA, "R6 exp 13", yo, 24'h0002AA);
    // R5 exponent 11 inserts the leading bit
    xfer(24'h0, 16'h5805, wo, yo);
    chk(yo == 24'h000805, "R5 exp 11 leading bit", yo, 24'h000805);

    // R7 round trip over a spread of samples
    for (int i = 0; i < 300; i++) begin
      logic [23:0] x;
      logic [15:0] w;
      int e;
      bit ok;
      if (i < 40) x = 24'(i - 20) + ((i % 2) ? 24'hFFF000 : 24'h000FE0);
      else        x = 24'(i * 55997 + i * i * 131);
      xfer(x, 16'h0, w, yo);
      xfer(24'h0, w, wo, yo);
      e = lead(x);
      if (e >= 11) ok = (yo == x);
      else ok = ($signed(yo) <= $signed(x)) &&
                (($signed(x) - $signed(yo)) < (32'sd1 <<< (11 - e)));
      chk(ok, "R7 round trip", yo, x);
      chk(w[14:11] == 4'(e), "R2 exponent count", {20'd0, w[14:11]}, 24'(e));
    end

    // R8 back-pressure on both directions
    @(negedge clk);
    pk_out_ready = 1'b0; up_out_ready = 1'b0;
    pk_in_valid = 1'b1; pk_in_data = 24'h000005;
    up_in_valid = 1'b1; up_in_data = 16'h6005;
    @(negedge clk);
    chk(pk_out_data == 16'h6005 && pk_out_valid, "R8 first word", {8'd0, pk_out_data}, 24'h6005);
    chk(!pk_in_ready && !up_in_ready, "R8 ready low when full",
        {22'd0, pk_in_ready, up_in_ready}, 24'd0);
    pk_in_data = 24'hFFFFFF; up_in_data = 16'hE7FF;
    repeat (2) @(negedge clk);
    chk(pk_out_data == 16'h6005 && pk_out_valid, "R8 stalled word held", {8'd0, pk_out_data}, 24'h6005);
    chk(up_out_data == 24'h000005 && up_out_valid, "R8 stalled sample held", up_out_data, 24'h000005);
    pk_out_ready = 1'b1; up_out_ready = 1'b1;
    @(negedge clk);
    chk(pk_out_data == 16'hE7FF, "R8 next word after release", {8'd0, pk_out_data}, 24'hE7FF);
    chk(up_out_data == 24'hFFFFFF, "R8 next sample after release", up_out_data, 24'hFFFFFF);
    pk_in_valid = 1'b0; up_in_valid = 1'b0;
    @(negedge clk);
    chk(!pk_out_valid && !up_out_valid, "R8 valid drops when drained",
        {22'd0, pk_out_valid, up_out_valid}, 24'd0);

    // R9 reset with a pending result
    pk_out_ready = 1'b0; up_out_ready = 1'b0;
    pk_in_valid = 1'b1; up_in_valid = 1'b1;
    @(negedge clk);
    pk_in_valid = 1'b0; up_in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(!pk_out_valid && !up_out_valid, "R9 reset clears pending",
        {22'd0, pk_out_valid, up_out_valid}, 24'd0);
    @(negedge clk);
    rst_n = 1'b1;
    pk_out_ready = 1'b1; up_out_ready = 1'b1;
    @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule